// File: doc/BRIEF.md
# Bus-Read Test-and-Set Lock Bank

This block is a small set of mutual-exclusion flags placed in a peripheral address window. Software running on several hardware threads claims a flag by reading its address. The read is an indivisible test-and-set: if the flag was clear it becomes set, and the reader gets 1. If it was already set it stays set, and the reader gets 0. A thread that gets 0 simply reads again until it wins. The owner gives the flag back by writing zero to the same address.

No special instruction is needed, because the side effect of an ordinary bus read does the whole atomic step. A write is taken in one cycle. A read presents its address in one cycle, and its result appears on the read-data port in the following cycle. The number of flags and the base of the address window are parameters. Flag `k` lives at address `BASE_ADDR + k`.

Top module: `tas_lock_unit`

## Requirements
- R1: After a synchronous reset every flag is clear and `bus_rdata` is 0.
- R2: A read (`bus_rd`=1) of address `BASE_ADDR+k` while flag `k` is clear sets flag `k`. `bus_rdata` equals 1 in the cycle after the read.
- R3: A read of a flag that is already set returns 0 in the cycle after the read, and the flag stays set.
- R4: A write (`bus_wr`=1, `bus_rd`=0) of data 0 to `BASE_ADDR+k` clears flag `k` at that clock edge, so the next read of it returns 1.
- R5: A write of any nonzero data leaves the addressed flag unchanged.
- R6: An address outside `BASE_ADDR` to `BASE_ADDR+NUM_LOCKS-1` reads as 0 and changes no flag, for reads and for writes alike.
- R7: Two reads of the same clear flag in consecutive cycles return 1 and then 0. The test and the set share one clock edge.
- R8: `bus_rdata` is 0 in every cycle that does not directly follow an accepted read.
- R9: When `bus_rd` and `bus_wr` are both high in one cycle, the read is performed and the write is ignored.
- R10: An operation on one flag leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe; a read performs test-and-set |
| bus_wr | input | 1 | Write strobe; writing zero releases a flag |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read result, valid the cycle after a read |

## Verification
The hardest situation to reach is two contenders hitting one clear flag in adjacent cycles. This case only shows whether the test and the set really happen in a single edge. The bench reproduces it by holding `bus_rd` high across two clock edges on one address and sampling both registered results. It also drives read and write together at one address, so that the read-over-write precedence shows on a held flag and on a free one. Flag state cannot be observed directly, so every "no effect" check is closed by a follow-up read. A result of 0 proves the flag stayed held, and a result of 1 proves it stayed clear.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;

  // Operation decoded from one bus cycle for the lock bank
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TRY  = 2'd1,
    OP_FREE = 2'd2
  } lock_op_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lock_addr_dec.sv
module lock_addr_dec
  import tas_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_LOCKS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  input  logic                 wdata_zero,
  output lock_op_e             op,
  output logic [NUM_LOCKS-1:0] sel
);

  logic hit;

  // One comparator per flag; the selects form a one-hot vector
  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_match
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + g);
    assign sel[g] = (addr == MY_ADDR);
  end

  assign hit = |sel;

  // Read wins over write in the same cycle
  always_comb begin
    op = OP_NONE;
    if (hit && rd) begin
      op = OP_TRY;
    end else if (hit && wr && wdata_zero) begin
      op = OP_FREE;
    end
  end

endmodule

// File: rtl/lock_cell.sv
module lock_cell
  import tas_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sel,
  input  lock_op_e op,
  output logic     held,
  output logic     grant
);

  // Grant is evaluated on the pre-edge state: the test half of test-and-set
  assign grant = sel && (op == OP_TRY) && !held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
    end else if (sel) begin
      if (op == OP_TRY) begin
        held <= 1'b1;
      end else if (op == OP_FREE) begin
        held <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lock_rd_reg.sv
module lock_rd_reg #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_LOCKS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOCKS-1:0] grant,
  output logic [DATA_W-1:0]    rdata
);

  // At most one grant is set; any grant means the reader won
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= {{(DATA_W-1){1'b0}}, |grant};
    end
  end

endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit
  import tas_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_LOCKS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  lock_op_e             op;
  logic [NUM_LOCKS-1:0] sel;
  logic [NUM_LOCKS-1:0] lock_held;
  logic [NUM_LOCKS-1:0] lock_grant;
  logic                 wdata_zero;

  assign wdata_zero = (bus_wdata == '0);

  lock_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_LOCKS (NUM_LOCKS),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .addr       (bus_addr),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .wdata_zero (wdata_zero),
    .op         (op),
    .sel        (sel)
  );

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    lock_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .sel   (sel[g]),
      .op    (op),
      .held  (lock_held[g]),
      .grant (lock_grant[g])
    );
  end

  lock_rd_reg #(
    .DATA_W    (DATA_W),
    .NUM_LOCKS (NUM_LOCKS)
  ) u_rd (
    .clk   (clk),
    .rst   (rst),
    .grant (lock_grant),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/tas_lock_unit_chk.sv
module tas_lock_unit_chk
  import tas_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_LOCKS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LOCKS-1:0] lock_held
);

  localparam int unsigned IW = idx_width(NUM_LOCKS);

  logic          in_range;
  logic [IW-1:0] idx;

  always_comb begin
    int unsigned a;
    a        = 32'(bus_addr);
    in_range = (a >= 32'(BASE_ADDR)) && (a < 32'(BASE_ADDR) + NUM_LOCKS);
    idx      = IW'(a - 32'(BASE_ADDR));
  end

  assert_acquire_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_range && !lock_held[idx]) |=>
      (bus_rdata == DATA_W'(1)) && lock_held[$past(idx)]);

  assert_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_range && lock_held[idx]) |=>
      (bus_rdata == '0) && lock_held[$past(idx)]);

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && in_range && bus_wdata == '0) |=>
      !lock_held[$past(idx)]);

  assert_nonzero_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_wdata != '0) |=> $stable(lock_held));

  assert_outside_R6: assert property (@(posedge clk) disable iff (rst)
    (!in_range) |=> $stable(lock_held) && (bus_rdata == '0));

  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd) |=> (bus_rdata == '0));

  assert_single_grant_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || !in_range) |=> ($countones(lock_held & ~$past(lock_held)) == 0));

endmodule

bind tas_lock_unit tas_lock_unit_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_LOCKS (NUM_LOCKS),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .lock_held (lock_held)
);

// File: tb/tas_lock_unit_tb.sv
`timescale 1ns/1ps
module tas_lock_unit_tb;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NL     = 8;
  localparam logic [7:0]  BASE   = 8'h40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tas_lock_unit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCKS(NL), .BASE_ADDR(BASE)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Read with one cycle of strobe; result is sampled one edge later
  task automatic rd(input logic [7:0] a, output int res);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    res = int'(bus_rdata);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset_R1();
    int r;
    do_reset();
    chk("R1 rdata after reset", int'(bus_rdata), 0);
    for (int k = 0; k < NL; k++) begin
      rd(8'(BASE + k), r);
      chk("R1 flag clear after reset", r, 1);
    end
    do_reset();
  endtask

  task automatic t_acquire_busy_R2_R3();
    int r;
    rd(BASE + 8'd3, r);  chk("R2 first read wins", r, 1);
    rd(BASE + 8'd3, r);  chk("R3 held read loses", r, 0);
    rd(BASE + 8'd3, r);  chk("R3 flag stays held", r, 0);
  endtask

  task automatic t_release_R4();
    int r;
    wr(BASE + 8'd3, 8'h00);
    rd(BASE + 8'd3, r);  chk("R4 zero write frees", r, 1);
  endtask

  task automatic t_nonzero_R5();
    int r;
    wr(BASE + 8'd3, 8'h01);
    rd(BASE + 8'd3, r);  chk("R5 nonzero write keeps held", r, 0);
    wr(BASE + 8'd3, 8'hFF);
    rd(BASE + 8'd3, r);  chk("R5 all-ones write keeps held", r, 0);
    wr(BASE + 8'd5, 8'h80);
    rd(BASE + 8'd5, r);  chk("R5 nonzero write does not set", r, 1);
  endtask

  task automatic t_outside_R6();
    int r;
    rd(BASE - 8'd1, r);  chk("R6 below window reads 0", r, 0);
    rd(BASE + 8'(NL), r); chk("R6 above window reads 0", r, 0);
    rd(BASE + 8'(NL), r); chk("R6 above window still 0", r, 0);
    wr(BASE + 8'(NL), 8'h00);
    wr(BASE - 8'd1, 8'h00);
    rd(BASE + 8'd3, r);  chk("R6 outside write keeps flag 3", r, 0);
    rd(BASE + 8'd6, r);  chk("R6 outside read did not touch 6", r, 1);
  endtask

  task automatic t_back_to_back_R7();
    int r1, r2;
    @(negedge clk);
    bus_addr = BASE + 8'd1; bus_rd = 1'b1;
    @(negedge clk);
    r1 = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
    r2 = int'(bus_rdata);
    chk("R7 first of pair", r1, 1);
    chk("R7 second of pair", r2, 0);
  endtask

  task automatic t_idle_R8();
    int r;
    rd(BASE + 8'd2, r);  chk("R8 read result present", r, 1);
    @(negedge clk);
    chk("R8 idle cycle rdata", int'(bus_rdata), 0);
    wr(BASE + 8'd2, 8'h00);
    chk("R8 rdata after write", int'(bus_rdata), 0);
  endtask

  task automatic t_rd_wr_R9();
    int r;
    // flag 4 held, then read+write-zero together: read wins, flag stays held
    rd(BASE + 8'd4, r);  chk("R9 setup take", r, 1);
    @(negedge clk);
    bus_addr = BASE + 8'd4; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R9 combined on held reads 0", int'(bus_rdata), 0);
    rd(BASE + 8'd4, r);  chk("R9 write ignored, still held", r, 0);
    // free flag 7 with combined access: read takes it
    @(negedge clk);
    bus_addr = BASE + 8'd7; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R9 combined on free reads 1", int'(bus_rdata), 1);
    rd(BASE + 8'd7, r);  chk("R9 flag 7 now held", r, 0);
  endtask

  task automatic t_independent_R10();
    int r;
    do_reset();
    rd(BASE + 8'd0, r);  chk("R10 take 0", r, 1);
    rd(BASE + 8'(NL-1), r); chk("R10 take last", r, 1);
    wr(BASE + 8'd0, 8'h00);
    rd(BASE + 8'(NL-1), r); chk("R10 last unaffected by release of 0", r, 0);
    rd(BASE + 8'd1, r);  chk("R10 neighbour 1 still clear", r, 1);
    rd(BASE + 8'd0, r);  chk("R10 flag 0 retaken", r, 1);
  endtask

  initial begin
    t_reset_R1();
    t_acquire_busy_R2_R3();
    t_release_R4();
    rd(BASE + 8'd3, total_dummy);
    t_nonzero_R5();
    t_outside_R6();
    t_back_to_back_R7();
    t_idle_R8();
    t_rd_wr_R9();
    t_independent_R10();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int total_dummy;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..all: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule